// File: doc/BRIEF.md
# Multi-Copy Ring Cache with Second-Chance Reclaim

This block keeps a ring of page slots that acts as a second-level cache below a primary page buffer. Each page that the primary buffer evicts is written into the slot at the tail pointer, in the order it arrives. The same logical page may be written again later. The older slots then stay in the ring as dead copies, and only the newest slot holds the live copy. A page table indexed by logical page number records whether a live copy exists and which slot holds it. Lookups go through this table. A lookup hit marks the live copy as recently referenced.

A reclaim pass starts when the number of free slots drops below a low-water mark that the user sets. The pass walks a batch of consecutive slots starting at the head pointer, one slot per cycle:
- Dead copies are dropped.
- A live copy that was referenced loses its mark and is written again at the tail, where it counts as a new entry.
- A live copy that was not referenced is released, and its page leaves the table. If that page was dirty, the block pulses a writeback request that carries the page number.

Appends are refused while the ring is full or while a pass is running.

Top module: `multicopy_ring_cache`

## Requirements
- R1: After reset the ring is empty and slots fill from slot 0 upward. An accepted append stores the page in the tail slot, advances the tail modulo NSLOT and raises `occupancy` by one in the next cycle.
- R2: Appending a page that already has a live copy moves its table entry to the new slot. The old slot becomes a dead copy that still counts in `occupancy` until a reclaim pass frees it. A later lookup reports the new slot.
- R3: A lookup presented in cycle t produces `lk_ack` in cycle t+1. For a page with a live copy, the same cycle shows `lk_hit`=1 and `lk_slot` equal to the slot index. The hit sets that copy's reference mark.
- R4: A lookup of a page with no live copy returns `lk_hit`=0 and `lk_slot`=0.
- R5: While idle with a non-empty ring, if NSLOT minus `occupancy` is less than `low_water`, then `reclaiming` goes high in the next cycle. The pass examines one head slot per cycle, for at most BATCH slots. It stops early if the ring becomes empty.
- R6: A live, referenced head slot is moved to the tail with its mark cleared, and `occupancy` does not change. It produces no writeback, and a later lookup reports the new slot.
- R7: A live, unreferenced, dirty head slot is released. In the next cycle `wb_valid` pulses with `wb_page` equal to that page, and later lookups of the page miss.
- R8: A live, unreferenced, clean head slot, or a dead copy, is released without a writeback. A released page misses on later lookups.
- R9: `app_ready` is low while `occupancy` equals NSLOT or while `reclaiming` is high. An append offered while `app_ready` is low changes neither `occupancy` nor the ring contents.
- R10: A lookup hit that falls in the same cycle in which the reclaim pass examines that page's slot counts as a reference. The page is moved to the tail and no writeback occurs.
- R11: During and right after reset, `app_ready`=1, `occupancy`=0, and `reclaiming`, `lk_ack` and `wb_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| low_water | input | $clog2(NSLOT+1) | Free-slot threshold that starts a reclaim pass |
| app_valid | input | 1 | Append request |
| app_page | input | $clog2(NPAGE) | Logical page to append |
| app_dirty | input | 1 | Appended page is modified |
| app_ready | output | 1 | Append accepted this cycle |
| lk_valid | input | 1 | Lookup request |
| lk_page | input | $clog2(NPAGE) | Logical page to look up |
| lk_ack | output | 1 | Lookup response valid |
| lk_hit | output | 1 | Page has a live copy |
| lk_slot | output | $clog2(NSLOT) | Slot of the live copy, 0 on a miss |
| wb_valid | output | 1 | Writeback request pulse |
| wb_page | output | $clog2(NPAGE) | Page to write back |
| reclaiming | output | 1 | Reclaim pass in progress |
| occupancy | output | $clog2(NSLOT+1) | Slots in use, including dead copies |

## Verification
A lookup can land in the same cycle in which the reclaim pass examines the slot holding that page. The block must then treat the lookup as a reference, so the page survives instead of being written back. A directed sequence counts the cycles from the threshold crossing and presents the lookup exactly in the cycle that examines that slot. It then checks three things: the page's new slot number, that the page still hits, and that no writeback carries that page. Random traffic with a small page space and a mid-range low-water mark makes this overlap happen many more times. Each time, the outputs are compared against a cycle-level model kept in the bench.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/mcr_ring_ptrs.sv
module mcr_ring_ptrs #(
    parameter  int unsigned NSLOT = 16,
    localparam int unsigned SW    = mcr_pkg::idx_bits(NSLOT),
    localparam int unsigned CW    = $clog2(NSLOT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [SW-1:0] head,
    output logic [SW-1:0] tail,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [SW-1:0] head;
        logic [SW-1:0] tail;
        logic [CW-1:0] count;
    } ring_t;

    ring_t r_q, r_d;

    function automatic logic [SW-1:0] step(input logic [SW-1:0] p);
        return (p == SW'(NSLOT - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        r_d = r_q;
        if (push) r_d.tail = step(r_q.tail);
        if (pop)  r_d.head = step(r_q.head);
        case ({push, pop})
            2'b10:   r_d.count = r_q.count + 1'b1;
            2'b01:   r_d.count = r_q.count - 1'b1;
            default: r_d.count = r_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign head  = r_q.head;
    assign tail  = r_q.tail;
    assign count = r_q.count;

endmodule

// File: rtl/mcr_page_table.sv
module mcr_page_table #(
    parameter  int unsigned NPAGE = 8,
    parameter  int unsigned NSLOT = 16,
    localparam int unsigned PW    = mcr_pkg::idx_bits(NPAGE),
    localparam int unsigned SW    = mcr_pkg::idx_bits(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_page,
    input  logic          wr_present,
    input  logic [SW-1:0] wr_slot,
    input  logic [PW-1:0] a_page,
    output logic          a_present,
    output logic [SW-1:0] a_slot,
    input  logic [PW-1:0] b_page,
    output logic          b_present,
    output logic [SW-1:0] b_slot
);

    typedef struct packed {
        logic [NPAGE-1:0]         present;
        logic [NPAGE-1:0][SW-1:0] slot;
    } table_t;

    table_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (wr_en) begin
            t_d.present[wr_page] = wr_present;
            t_d.slot[wr_page]    = wr_slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign a_present = t_q.present[a_page];
    assign a_slot    = t_q.slot[a_page];
    assign b_present = t_q.present[b_page];
    assign b_slot    = t_q.slot[b_page];

endmodule

// File: rtl/multicopy_ring_cache.sv
module multicopy_ring_cache #(
    parameter  int unsigned NSLOT = 16,
    parameter  int unsigned NPAGE = 8,
    parameter  int unsigned BATCH = 4,
    localparam int unsigned SW    = mcr_pkg::idx_bits(NSLOT),
    localparam int unsigned PW    = mcr_pkg::idx_bits(NPAGE),
    localparam int unsigned CW    = $clog2(NSLOT + 1),
    localparam int unsigned BW    = $clog2(BATCH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] low_water,
    input  logic          app_valid,
    input  logic [PW-1:0] app_page,
    input  logic          app_dirty,
    output logic          app_ready,
    input  logic          lk_valid,
    input  logic [PW-1:0] lk_page,
    output logic          lk_ack,
    output logic          lk_hit,
    output logic [SW-1:0] lk_slot,
    output logic          wb_valid,
    output logic [PW-1:0] wb_page,
    output logic          reclaiming,
    output logic [CW-1:0] occupancy
);
    import mcr_pkg::*;

    localparam logic [CW-1:0] SLOTS_C = CW'(NSLOT);

    typedef struct packed {
        logic          live;
        logic          refd;
        logic          dirty;
        logic [PW-1:0] page;
    } slot_t;

    typedef struct packed {
        slot_t [NSLOT-1:0] slots;
        scan_state_e       st;
        logic [BW-1:0]     left;
        logic              lk_ack;
        logic              lk_hit;
        logic [SW-1:0]     lk_slot;
        logic              wb_valid;
        logic [PW-1:0]     wb_page;
    } core_t;

    core_t c_q, c_d;

    logic [SW-1:0] head, tail;
    logic [CW-1:0] count;
    logic          push, pop;
    logic          map_we, map_pres;
    logic [PW-1:0] map_pg;
    logic [SW-1:0] map_slot;
    logic          a_present, b_present;
    logic [SW-1:0] a_slot, b_slot;

    logic          lk_hit_now, app_fire, scan_step, head_ref;
    slot_t         head_e;

    mcr_ring_ptrs #(.NSLOT(NSLOT)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .head  (head),
        .tail  (tail),
        .count (count)
    );

    mcr_page_table #(.NPAGE(NPAGE), .NSLOT(NSLOT)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (map_we),
        .wr_page    (map_pg),
        .wr_present (map_pres),
        .wr_slot    (map_slot),
        .a_page     (lk_page),
        .a_present  (a_present),
        .a_slot     (a_slot),
        .b_page     (app_page),
        .b_present  (b_present),
        .b_slot     (b_slot)
    );

    assign app_ready = (c_q.st == ST_IDLE) && (count != SLOTS_C);

    always_comb begin
        c_d      = c_q;
        push     = 1'b0;
        pop      = 1'b0;
        map_we   = 1'b0;
        map_pg   = '0;
        map_pres = 1'b0;
        map_slot = '0;

        lk_hit_now = lk_valid && a_present;
        app_fire   = app_valid && app_ready;
        scan_step  = (c_q.st == ST_SCAN) && (count != '0);
        head_e     = c_q.slots[head];
        // a hit landing on the slot under inspection counts as a reference
        head_ref   = head_e.refd || (lk_hit_now && (a_slot == head));

        c_d.lk_ack   = lk_valid;
        c_d.lk_hit   = lk_hit_now;
        c_d.lk_slot  = lk_hit_now ? a_slot : '0;
        c_d.wb_valid = 1'b0;
        c_d.wb_page  = '0;

        if (lk_hit_now) c_d.slots[a_slot].refd = 1'b1;

        if (app_fire) begin
            if (b_present) c_d.slots[b_slot].live = 1'b0;
            c_d.slots[tail] = '{live: 1'b1, refd: 1'b0, dirty: app_dirty, page: app_page};
            map_we   = 1'b1;
            map_pg   = app_page;
            map_pres = 1'b1;
            map_slot = tail;
            push     = 1'b1;
        end

        if (scan_step) begin
            pop = 1'b1;
            c_d.slots[head].live = 1'b0;
            c_d.slots[head].refd = 1'b0;
            if (head_e.live && head_ref) begin
                // second chance: the tail write wins when head equals tail
                c_d.slots[tail] = '{live: 1'b1, refd: 1'b0, dirty: head_e.dirty, page: head_e.page};
                push     = 1'b1;
                map_we   = 1'b1;
                map_pg   = head_e.page;
                map_pres = 1'b1;
                map_slot = tail;
            end else if (head_e.live) begin
                map_we   = 1'b1;
                map_pg   = head_e.page;
                map_pres = 1'b0;
                if (head_e.dirty) begin
                    c_d.wb_valid = 1'b1;
                    c_d.wb_page  = head_e.page;
                end
            end
        end

        case (c_q.st)
            ST_IDLE: begin
                if ((count != '0) && ((SLOTS_C - count) < low_water)) begin
                    c_d.st   = ST_SCAN;
                    c_d.left = BW'(BATCH);
                end
            end
            default: begin
                if ((count == '0) || (c_q.left == BW'(1))) c_d.st = ST_IDLE;
                else                                       c_d.left = c_q.left - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign lk_ack     = c_q.lk_ack;
    assign lk_hit     = c_q.lk_hit;
    assign lk_slot    = c_q.lk_slot;
    assign wb_valid   = c_q.wb_valid;
    assign wb_page    = c_q.wb_page;
    assign reclaiming = (c_q.st == ST_SCAN);
    assign occupancy  = count;

endmodule

// File: rtl/mcr_checker.sv
module mcr_checker #(
    parameter  int unsigned NSLOT = 16,
    localparam int unsigned SW    = mcr_pkg::idx_bits(NSLOT),
    localparam int unsigned CW    = $clog2(NSLOT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] low_water,
    input logic          app_valid,
    input logic          app_ready,
    input logic          lk_valid,
    input logic          lk_ack,
    input logic          lk_hit,
    input logic [SW-1:0] lk_slot,
    input logic          wb_valid,
    input logic          reclaiming,
    input logic [CW-1:0] occupancy
);

    p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occupancy) <= int'(NSLOT));

    p_append_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (app_valid && app_ready) |=> (int'(occupancy) == int'($past(occupancy)) + 1));

    p_ack_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_ack);

    p_miss_slot_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_ack && !lk_hit) |-> (lk_slot == '0));

    p_scan_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!reclaiming && occupancy != '0 && (int'(NSLOT) - int'(occupancy)) < int'(low_water))
        |=> reclaiming);

    p_reclaim_no_growth_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reclaiming |=> (occupancy <= $past(occupancy)));

    p_wb_from_scan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(reclaiming));

    p_full_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occupancy) == int'(NSLOT)) |-> !app_ready);

    p_scan_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reclaiming |-> !app_ready);

endmodule

bind multicopy_ring_cache mcr_checker #(.NSLOT(NSLOT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .low_water  (low_water),
    .app_valid  (app_valid),
    .app_ready  (app_ready),
    .lk_valid   (lk_valid),
    .lk_ack     (lk_ack),
    .lk_hit     (lk_hit),
    .lk_slot    (lk_slot),
    .wb_valid   (wb_valid),
    .reclaiming (reclaiming),
    .occupancy  (occupancy)
);

// File: tb/sim_multicopy_ring_cache.sv
module sim_multicopy_ring_cache;

    localparam int NSLOT  = 16;
    localparam int NPAGE  = 8;
    localparam int BATCH  = 4;
    localparam int SW     = 4;
    localparam int PW     = 3;
    localparam int CW     = 5;
    localparam time TCLK  = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] low_water = '0;
    logic          app_valid = 1'b0;
    logic [PW-1:0] app_page = '0;
    logic          app_dirty = 1'b0;
    logic          app_ready;
    logic          lk_valid = 1'b0;
    logic [PW-1:0] lk_page = '0;
    logic          lk_ack, lk_hit, wb_valid, reclaiming;
    logic [SW-1:0] lk_slot;
    logic [PW-1:0] wb_page;
    logic [CW-1:0] occupancy;

    int n_checks = 0;
    int n_err    = 0;
    int cycles   = 0;
    bit [NPAGE-1:0] wb_mask = '0;

    always #(TCLK/2) clk = ~clk;

    multicopy_ring_cache #(.NSLOT(NSLOT), .NPAGE(NPAGE), .BATCH(BATCH)) u0 (
        .clk(clk), .rst_n(rst_n), .low_water(low_water),
        .app_valid(app_valid), .app_page(app_page), .app_dirty(app_dirty), .app_ready(app_ready),
        .lk_valid(lk_valid), .lk_page(lk_page), .lk_ack(lk_ack), .lk_hit(lk_hit), .lk_slot(lk_slot),
        .wb_valid(wb_valid), .wb_page(wb_page), .reclaiming(reclaiming), .occupancy(occupancy)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // ---------------- cycle-level expectation model ----------------
    bit m_live [NSLOT];
    bit m_ref  [NSLOT];
    bit m_dirty[NSLOT];
    int m_page [NSLOT];
    bit m_pres [NPAGE];
    int m_slot [NPAGE];
    int m_head, m_tail, m_cnt, m_left;
    bit m_scan;
    bit e_ack, e_hit, e_wb;
    int e_slot, e_wbp;

    function automatic int nxt(input int p);
        return (p == NSLOT - 1) ? 0 : p + 1;
    endfunction

    function automatic bit exp_ready();
        return !m_scan && (m_cnt != NSLOT);
    endfunction

    always @(posedge clk) begin
        bit hit, fire, step, was_scan;
        int hs, h, pg, old_cnt;
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) begin
                m_live[i] = 0; m_ref[i] = 0; m_dirty[i] = 0; m_page[i] = 0;
            end
            for (int i = 0; i < NPAGE; i++) begin m_pres[i] = 0; m_slot[i] = 0; end
            m_head = 0; m_tail = 0; m_cnt = 0; m_left = 0; m_scan = 0;
            e_ack = 0; e_hit = 0; e_wb = 0; e_slot = 0; e_wbp = 0;
        end else begin
            hit      = lk_valid && m_pres[lk_page];
            hs       = m_slot[lk_page];
            fire     = app_valid && exp_ready();
            step     = m_scan && (m_cnt != 0);
            was_scan = m_scan;
            old_cnt  = m_cnt;
            e_ack = lk_valid; e_hit = hit; e_slot = hit ? hs : 0; e_wb = 0; e_wbp = 0;
            if (hit) m_ref[hs] = 1;
            if (fire) begin
                if (m_pres[app_page]) m_live[m_slot[app_page]] = 0;
                m_live[m_tail] = 1; m_ref[m_tail] = 0; m_dirty[m_tail] = app_dirty; m_page[m_tail] = app_page;
                m_pres[app_page] = 1; m_slot[app_page] = m_tail;
                m_tail = nxt(m_tail); m_cnt++;
            end
            if (step) begin
                h = m_head; pg = m_page[h];
                if (m_live[h] && m_ref[h]) begin
                    bit dty;
                    dty = m_dirty[h];
                    m_live[h] = 0; m_ref[h] = 0;
                    m_live[m_tail] = 1; m_ref[m_tail] = 0; m_dirty[m_tail] = dty; m_page[m_tail] = pg;
                    m_slot[pg] = m_tail;
                    m_tail = nxt(m_tail); m_head = nxt(m_head);
                end else begin
                    if (m_live[h]) begin
                        m_pres[pg] = 0;
                        if (m_dirty[h]) begin e_wb = 1; e_wbp = pg; end
                    end
                    m_live[h] = 0; m_ref[h] = 0;
                    m_head = nxt(m_head); m_cnt--;
                end
            end
            if (!was_scan) begin
                if (old_cnt != 0 && (NSLOT - old_cnt) < int'(low_water)) begin
                    m_scan = 1; m_left = BATCH;
                end
            end else begin
                if (old_cnt == 0 || m_left == 1) m_scan = 0;
                else m_left--;
            end
        end
    end

    // ---------------- per-cycle comparison, off the active edge ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            chk(app_ready == exp_ready(), "R9", "app_ready", app_ready, exp_ready());
            chk(int'(occupancy) == m_cnt, "R1", "occupancy", occupancy, m_cnt);
            chk(reclaiming == m_scan, "R5", "reclaiming", reclaiming, m_scan);
            chk(lk_ack == e_ack, "R3", "lk_ack", lk_ack, e_ack);
            if (e_ack) chk(lk_hit == e_hit, e_hit ? "R3" : "R4", "lk_hit", lk_hit, e_hit);
            if (e_ack && e_hit) chk(int'(lk_slot) == e_slot, "R2", "lk_slot", lk_slot, e_slot);
            chk(wb_valid == e_wb, e_wb ? "R7" : "R8", "wb_valid", wb_valid, e_wb);
            if (e_wb) chk(int'(wb_page) == e_wbp, "R7", "wb_page", wb_page, e_wbp);
            if (wb_valid) wb_mask[wb_page] = 1'b1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_checks++; n_err++;
            $display("FAIL R5 watchdog: actual %0d expected %0d", cycles, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_reset();
        rst_n = 1'b0; app_valid = 0; lk_valid = 0; low_water = '0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic append(input int pg, input bit dty);
        app_valid = 1; app_page = PW'(pg); app_dirty = dty;
        @(negedge clk);
        app_valid = 0;
    endtask

    task automatic lookup(input int pg, output bit hit, output int slot);
        lk_valid = 1; lk_page = PW'(pg);
        @(negedge clk);
        hit = lk_hit; slot = int'(lk_slot);
        lk_valid = 0;
    endtask

    initial begin
        bit h;
        int s;
        void'($urandom(32'd1234));

        // reset state
        do_reset();
        chk(app_ready == 1, "R11", "ready after reset", app_ready, 1);
        chk(occupancy == 0, "R11", "occupancy after reset", occupancy, 0);
        chk(reclaiming == 0, "R11", "reclaiming after reset", reclaiming, 0);
        chk(lk_ack == 0 && wb_valid == 0, "R11", "ack/wb after reset", lk_ack | wb_valid, 0);
        @(negedge clk);

        // basic appends and lookups
        for (int i = 0; i < 4; i++) append(i, 0);
        lookup(2, h, s);
        chk(h == 1, "R3", "hit page 2", h, 1);
        chk(s == 2, "R1", "slot of page 2", s, 2);
        lookup(7, h, s);
        chk(h == 0 && s == 0, "R4", "miss page 7", {h, s[3:0]}, 0);
        append(2, 1);
        lookup(2, h, s);
        chk(s == 4, "R2", "new slot of page 2", s, 4);
        chk(occupancy == 5, "R2", "dead copy still occupies", occupancy, 5);

        // reclaim pass with a same-cycle lookup on the inspected slot
        do_reset();
        @(negedge clk);
        for (int i = 0; i < 8; i++) append(i, (i == 0) || (i == 2) || (i == 3));
        lookup(0, h, s);
        wb_mask = '0;
        low_water = CW'(16);
        @(negedge clk);          // trigger edge passed, pass now running
        low_water = '0;
        @(negedge clk);          // slot 0 examined
        @(negedge clk);          // slot 1 examined
        lk_valid = 1; lk_page = 3'd2;
        @(negedge clk);          // slot 2 examined together with the lookup
        lk_valid = 0;
        chk(lk_hit == 1, "R10", "same-cycle lookup hit", lk_hit, 1);
        repeat (3) @(negedge clk);
        chk(reclaiming == 0, "R5", "pass ended after batch", reclaiming, 0);
        chk(occupancy == 6, "R6", "occupancy after pass", occupancy, 6);
        lookup(0, h, s);
        chk(h == 1 && s == 8, "R6", "referenced page moved to slot 8", s, 8);
        lookup(2, h, s);
        chk(h == 1 && s == 9, "R10", "coinciding page moved to slot 9", s, 9);
        lookup(3, h, s);
        chk(h == 0, "R7", "dirty page released", h, 0);
        lookup(1, h, s);
        chk(h == 0, "R8", "clean page released", h, 0);
        chk(wb_mask == 8'b0000_1000, "R7", "writeback set", wb_mask, 8);

        // full ring stall
        do_reset();
        @(negedge clk);
        for (int i = 0; i < NSLOT; i++) append(i % NPAGE, 1);
        chk(app_ready == 0, "R9", "ready low when full", app_ready, 0);
        app_valid = 1; app_page = 3'd5;
        repeat (3) @(negedge clk);
        app_valid = 0;
        chk(occupancy == NSLOT, "R9", "append ignored when full", occupancy, NSLOT);
        lookup(5, h, s);
        chk(s == 13, "R9", "page 5 slot unchanged", s, 13);

        // constrained random traffic
        do_reset();
        low_water = CW'(5);
        @(negedge clk);
        for (int i = 0; i < 4000; i++) begin
            app_valid = ($urandom % 3) != 0;
            app_page  = PW'($urandom % NPAGE);
            app_dirty = $urandom % 2;
            lk_valid  = $urandom % 2;
            lk_page   = PW'($urandom % NPAGE);
            @(negedge clk);
        end
        app_valid = 0; lk_valid = 0;
        repeat (4) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule